// File: doc/BRIEF.md
# Subroutine Call and Return Sequencer

This block carries out the control-flow side of subroutine linkage for a small processor core. When the core issues a call, the block keeps the return address, which is the program counter value that already points past the call, and steers the program counter to the call target. When the core issues a return, the block restores the program counter from the saved address. Argument passing and instruction fetch are outside the block.

There are two linkage modes, and each command selects one. In link mode the return address goes into a single link register. This is one cycle per command and suits leaf routines, but a second call overwrites the first saved address. In stack mode return addresses go to a memory-resident stack that grows toward lower addresses and is addressed by a stack pointer. Calls therefore nest to any depth the stack region allows. The stack region lies between a configurable lower limit and the initial base. A call that would leave the region, or a return from an empty stack, is refused and reported.

The memory port is one word wide and uses byte addresses. Write data is committed on a clock edge. Read data is returned combinationally in the same cycle as the request.

Top module: `callret_seq`

## Requirements
- R1: After reset `pcOut` equals `RESET_PC`, `spOut` equals `STACK_BASE`, and `done`, `ovfErr`, `unfErr` and `busy` are low.
- R2: A link-mode call (`useLink`=1, `cmdRet`=0) accepted on a clock edge copies `curPc` into the link register and makes `pcOut` equal `cmdTarget` directly after that edge. `done` is high for that one cycle.
- R3: A link-mode return (`useLink`=1, `cmdRet`=1) makes `pcOut` equal the link register directly after the accepting edge, with `done` high for that cycle.
- R4: A stack-mode call first lowers the stack pointer by 4. It then writes `curPc` to the word at the new stack pointer, in the cycle after acceptance, with `memWe`=1 and `memAddr` = old `spOut` − 4. After the following edge `pcOut` equals `cmdTarget`, `spOut` is 4 lower, and `done` is high.
- R5: A stack-mode return reads the word at `spOut` in the cycle after acceptance, with `memEn`=1 and `memWe`=0. After the following edge `pcOut` equals that word, `spOut` is 4 higher, and `done` is high.
- R6: In stack mode, nested calls return their saved addresses in last-in, first-out order.
- R7: A stack-mode call with `spOut` − 4 below `STACK_LIMIT` is refused. `ovfErr` and `done` are high for one cycle directly after the accepting edge. PC, stack pointer and memory are left unchanged.
- R8: A stack-mode return with `spOut` + 4 above `STACK_BASE` (empty stack) is refused. `unfErr` and `done` are high for one cycle directly after the accepting edge. PC and stack pointer are left unchanged.
- R9: In link mode a nested call overwrites the earlier return address and raises no error, so two returns both go to the latest address.
- R10: A command presented while `busy` is high is ignored. It produces no `done` and changes neither the link register nor the PC.
- R11: Link-mode commands leave the stack pointer and memory untouched, and stack-mode commands leave the link register untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdRet | input | 1 | 1 = return, 0 = call |
| useLink | input | 1 | 1 = link-register mode, 0 = stack mode |
| cmdTarget | input | DW | Call target address |
| curPc | input | DW | Updated PC (points past the call) |
| pcOut | output | DW | Program counter produced by the block |
| spOut | output | DW | Stack pointer |
| done | output | 1 | Command finished (one-cycle pulse) |
| ovfErr | output | 1 | Call refused: stack would pass the limit |
| unfErr | output | 1 | Return refused: stack empty |
| busy | output | 1 | Stack transfer in progress |
| memEn | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | DW | Byte address of the access |
| memWdata | output | DW | Word to write |
| memRdata | input | DW | Word read, valid in the request cycle |

## Verification
The collision of interest is a new command arriving in the same cycle as a stack transfer. The memory write or read of the running command is under way in that cycle, and the block is `busy`. The bench provokes this by holding `cmdValid` for one more cycle after a stack call, with a link-mode call that carries a different target and return address. The outcome is judged at the ports in three ways. Exactly one `done` must appear. The PC must be the target of the original call. A later link-mode return must still go to the address saved before the stray command.

// File: rtl/callret_pkg.sv
package callret_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PUSH,
    ST_POP
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic latch;       // capture target and return address
    logic linkSave;    // link register <= curPc
    logic jumpTarget;  // pc <= cmdTarget (link call)
    logic jumpLink;    // pc <= link register
    logic push;        // write stack, sp -= step, pc <= latched target
    logic pop;         // read stack, sp += step, pc <= read word
  } seqStrobe_t;

endpackage

// File: rtl/callret_dp.sv
module callret_dp
  import callret_pkg::*;
#(
  parameter int unsigned    DW          = 32,
  parameter logic [DW-1:0]  RESET_PC    = '0,
  parameter logic [DW-1:0]  STACK_BASE  = 'h100,
  parameter logic [DW-1:0]  STACK_LIMIT = 'hF0
) (
  input  logic            clk,
  input  logic            rstN,
  input  seqStrobe_t      stb,
  input  logic [DW-1:0]   cmdTarget,
  input  logic [DW-1:0]   curPc,
  input  logic [DW-1:0]   memRdata,
  output logic [DW-1:0]   pcOut,
  output logic [DW-1:0]   spOut,
  output logic            spFull,
  output logic            spEmpty,
  output logic            memEn,
  output logic            memWe,
  output logic [DW-1:0]   memAddr,
  output logic [DW-1:0]   memWdata
);

  localparam int unsigned   SLOT_BYTES = DW / 8;
  localparam logic [DW-1:0] STEP       = DW'(SLOT_BYTES);

  logic [DW-1:0] pcReg, spReg, lrReg, tgtReg, retReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg  <= RESET_PC;
      spReg  <= STACK_BASE;
      lrReg  <= '0;
      tgtReg <= '0;
      retReg <= '0;
    end else begin
      if (stb.latch) begin
        tgtReg <= cmdTarget;
        retReg <= curPc;
      end
      if (stb.linkSave) lrReg <= curPc;
      if (stb.pop) begin
        pcReg <= memRdata;
        spReg <= spReg + STEP;
      end else if (stb.push) begin
        pcReg <= tgtReg;
        spReg <= spReg - STEP;
      end else if (stb.jumpTarget) begin
        pcReg <= cmdTarget;
      end else if (stb.jumpLink) begin
        pcReg <= lrReg;
      end
    end
  end

  // bounds: compare without wrapping below zero
  assign spFull  = spReg < (STACK_LIMIT + STEP);
  assign spEmpty = spReg >= STACK_BASE;

  assign memEn    = stb.push | stb.pop;
  assign memWe    = stb.push;
  assign memAddr  = stb.push ? (spReg - STEP) : spReg;
  assign memWdata = retReg;
  assign pcOut    = pcReg;
  assign spOut    = spReg;

endmodule

// File: rtl/callret_ctrl.sv
module callret_ctrl
  import callret_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRet,
  input  logic        useLink,
  input  logic        spFull,
  input  logic        spEmpty,
  output seqStrobe_t  stb,
  output logic        done,
  output logic        ovfErr,
  output logic        unfErr,
  output logic        busy
);

  seqState_t state, nextState;
  logic doneD, ovfD, unfD;

  always_comb begin
    stb       = '0;
    nextState = state;
    doneD     = 1'b0;
    ovfD      = 1'b0;
    unfD      = 1'b0;
    unique case (state)
      ST_IDLE: if (cmdValid) begin
        if (useLink) begin
          doneD = 1'b1;
          if (cmdRet) stb.jumpLink = 1'b1;
          else begin
            stb.linkSave   = 1'b1;
            stb.jumpTarget = 1'b1;
          end
        end else if (!cmdRet) begin
          if (spFull) begin
            ovfD  = 1'b1;
            doneD = 1'b1;
          end else begin
            stb.latch = 1'b1;
            nextState = ST_PUSH;
          end
        end else begin
          if (spEmpty) begin
            unfD  = 1'b1;
            doneD = 1'b1;
          end else begin
            nextState = ST_POP;
          end
        end
      end
      ST_PUSH: begin
        stb.push  = 1'b1;
        doneD     = 1'b1;
        nextState = ST_IDLE;
      end
      ST_POP: begin
        stb.pop   = 1'b1;
        doneD     = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      ovfErr <= 1'b0;
      unfErr <= 1'b0;
    end else begin
      state  <= nextState;
      done   <= doneD;
      ovfErr <= ovfD;
      unfErr <= unfD;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/callret_seq.sv
module callret_seq
  import callret_pkg::*;
#(
  parameter int unsigned    DW          = 32,
  parameter logic [DW-1:0]  RESET_PC    = '0,
  parameter logic [DW-1:0]  STACK_BASE  = 'h100,
  parameter logic [DW-1:0]  STACK_LIMIT = 'hF0
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic          cmdRet,
  input  logic          useLink,
  input  logic [DW-1:0] cmdTarget,
  input  logic [DW-1:0] curPc,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] spOut,
  output logic          done,
  output logic          ovfErr,
  output logic          unfErr,
  output logic          busy,
  output logic          memEn,
  output logic          memWe,
  output logic [DW-1:0] memAddr,
  output logic [DW-1:0] memWdata,
  input  logic [DW-1:0] memRdata
);

  seqStrobe_t stb;
  logic spFull, spEmpty;

  callret_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRet(cmdRet),
    .useLink(useLink), .spFull(spFull), .spEmpty(spEmpty), .stb(stb),
    .done(done), .ovfErr(ovfErr), .unfErr(unfErr), .busy(busy)
  );

  callret_dp #(
    .DW(DW), .RESET_PC(RESET_PC),
    .STACK_BASE(STACK_BASE), .STACK_LIMIT(STACK_LIMIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdTarget(cmdTarget),
    .curPc(curPc), .memRdata(memRdata), .pcOut(pcOut), .spOut(spOut),
    .spFull(spFull), .spEmpty(spEmpty), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata)
  );

endmodule

// File: rtl/callret_chk.sv
module callret_chk #(
  parameter int unsigned    DW          = 32,
  parameter logic [DW-1:0]  STACK_BASE  = 'h100,
  parameter logic [DW-1:0]  STACK_LIMIT = 'hF0
) (
  input logic          clk,
  input logic          rstN,
  input logic          memEn,
  input logic          memWe,
  input logic [DW-1:0] memAddr,
  input logic [DW-1:0] memRdata,
  input logic [DW-1:0] spOut,
  input logic [DW-1:0] pcOut,
  input logic          done,
  input logic          ovfErr,
  input logic          unfErr
);

  localparam logic [DW-1:0] STEP = DW'(DW / 8);

  p_push_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |-> (memAddr == spOut - STEP));

  p_push_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && memWe) |=> (spOut == $past(spOut) - STEP));

  p_pop_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |-> (memAddr == spOut));

  p_pop_pc_r5: assert property (@(posedge clk) disable iff (!rstN)
    (memEn && !memWe) |=> (pcOut == $past(memRdata) && spOut == $past(spOut) + STEP));

  p_sp_bounds_r7: assert property (@(posedge clk) disable iff (!rstN)
    (spOut >= STACK_LIMIT) && (spOut <= STACK_BASE));

  p_err_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ovfErr || unfErr) |-> (done && !(ovfErr && unfErr)));

  p_err_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfErr || unfErr) |-> $stable(spOut));

endmodule

bind callret_seq callret_chk #(
  .DW(DW), .STACK_BASE(STACK_BASE), .STACK_LIMIT(STACK_LIMIT)
) u_chk (
  .clk(clk), .rstN(rstN), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
  .memRdata(memRdata), .spOut(spOut), .pcOut(pcOut), .done(done),
  .ovfErr(ovfErr), .unfErr(unfErr)
);

// File: tb/callret_seq_bench.sv
module callret_seq_bench;

  localparam int unsigned   DW    = 32;
  localparam logic [31:0]   RPC   = 32'h0000_0040;
  localparam logic [31:0]   BASE  = 32'h0000_0100;
  localparam logic [31:0]   LIMIT = 32'h0000_00F0;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRet = 1'b0, useLink = 1'b0;
  logic [31:0] cmdTarget = '0, curPc = '0;
  logic [31:0] pcOut, spOut, memAddr, memWdata, memRdata;
  logic done, ovfErr, unfErr, busy, memEn, memWe;

  always #5 clk = ~clk;

  callret_seq #(.DW(DW), .RESET_PC(RPC), .STACK_BASE(BASE), .STACK_LIMIT(LIMIT)) u_callret_seq (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRet(cmdRet), .useLink(useLink),
    .cmdTarget(cmdTarget), .curPc(curPc), .pcOut(pcOut), .spOut(spOut), .done(done),
    .ovfErr(ovfErr), .unfErr(unfErr), .busy(busy), .memEn(memEn), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata)
  );

  // word memory, combinational read
  logic [31:0] mem [64];
  always @(posedge clk) if (memEn && memWe) mem[memAddr[7:2]] <= memWdata;
  assign memRdata = mem[memAddr[7:2]];

  int total = 0, bad = 0, cyc = 0, acceptCyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [31:0] pc;
    logic [31:0] sp;
    logic ovf;
    logic unf;
    int lat;
    string req;
  } exp_t;
  exp_t q[$];

  // reference state
  logic [31:0] pcM = RPC, spM = BASE, lrM = '0;
  logic [31:0] stk[$];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN && done) begin
      if (q.size() == 0) begin
        check(1'b0, "R10", "unexpected done", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(pcOut == e.pc, e.req, "pcOut", pcOut, e.pc);
        check(spOut == e.sp, e.req, "spOut (R11)", spOut, e.sp);
        check(ovfErr == e.ovf, e.req, "ovfErr", 32'(ovfErr), 32'(e.ovf));
        check(unfErr == e.unf, e.req, "unfErr", 32'(unfErr), 32'(e.unf));
        check(cyc - acceptCyc == e.lat, e.req, "latency",
              32'(cyc - acceptCyc), 32'(e.lat));
      end
    end
  end

  // driver
  task automatic issue(input bit isRet, input bit link, input logic [31:0] tgt,
                       input logic [31:0] cur, input string req, input bit junk);
    exp_t e;
    e.ovf = 1'b0; e.unf = 1'b0; e.req = req;
    if (link) begin
      e.lat = 1;
      if (isRet) pcM = lrM;
      else begin lrM = cur; pcM = tgt; end
    end else if (!isRet) begin
      if (spM < LIMIT + 32'd4) begin e.ovf = 1'b1; e.lat = 1; end
      else begin spM = spM - 32'd4; stk.push_back(cur); pcM = tgt; e.lat = 2; end
    end else begin
      if (spM >= BASE) begin e.unf = 1'b1; e.lat = 1; end
      else begin pcM = stk.pop_back(); spM = spM + 32'd4; e.lat = 2; end
    end
    e.pc = pcM; e.sp = spM;
    @(negedge clk);
    cmdValid = 1'b1; cmdRet = isRet; useLink = link; cmdTarget = tgt; curPc = cur;
    acceptCyc = cyc;
    q.push_back(e);
    @(negedge clk);
    if (junk) begin
      // stray link call during the stack transfer cycle
      cmdValid = 1'b1; cmdRet = 1'b0; useLink = 1'b1;
      cmdTarget = 32'h0000_BAD0; curPc = 32'h000D_EAD0;
    end else cmdValid = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(pcOut == RPC, "R1", "reset pcOut", pcOut, RPC);
    check(spOut == BASE, "R1", "reset spOut", spOut, BASE);
    check({done, ovfErr, unfErr, busy} == 4'b0, "R1", "reset flags",
          32'({done, ovfErr, unfErr, busy}), 32'd0);

    // R2 / R3 link call and return
    issue(0, 1, 32'h400, 32'h104, "R2", 0);
    issue(1, 1, 32'h0, 32'h0, "R3", 0);
    // R9 nested link calls overwrite
    issue(0, 1, 32'h500, 32'h204, "R9", 0);
    issue(0, 1, 32'h600, 32'h504, "R9", 0);
    issue(1, 1, 32'h0, 32'h0, "R9", 0);
    issue(1, 1, 32'h0, 32'h0, "R9", 0);

    // R4 / R6 stack pushes to the limit, then R7 overflow
    issue(0, 0, 32'h1000, 32'h0014, "R4", 0);
    issue(0, 0, 32'h2000, 32'h1008, "R6", 0);
    issue(0, 0, 32'h3000, 32'h200C, "R6", 0);
    issue(0, 0, 32'h4000, 32'h3010, "R6", 0);
    issue(0, 0, 32'h5000, 32'h4014, "R7", 0);
    // link call between stack calls leaves the stack alone (R11)
    issue(0, 1, 32'h7000, 32'h4444, "R11", 0);
    // R5 / R6 returns in LIFO order, then R8 underflow
    issue(1, 0, 32'h0, 32'h0, "R5", 0);
    issue(1, 0, 32'h0, 32'h0, "R6", 0);
    issue(1, 0, 32'h0, 32'h0, "R6", 0);
    issue(1, 0, 32'h0, 32'h0, "R6", 0);
    issue(1, 0, 32'h0, 32'h0, "R8", 0);

    // R10 command during the push cycle is dropped
    issue(0, 0, 32'h8800, 32'h0120, "R10", 1);
    issue(1, 0, 32'h0, 32'h0, "R10", 0);
    issue(1, 1, 32'h0, 32'h0, "R10", 0);
    // R10 command during the pop cycle is dropped
    issue(0, 0, 32'h9900, 32'h0200, "R5", 0);
    issue(1, 0, 32'h0, 32'h0, "R10", 1);
    issue(1, 1, 32'h0, 32'h0, "R10", 0);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule